// File: doc/BRIEF.md
# Multi-Source Reset Sequencing Controller

This block gathers the three ways a processor core can be sent back to its start address and turns them into one timed reset request. The causes are a rising edge on the external active-low reset pin, a one-cycle overrun strobe from the watchdog, and a one-cycle strobe that follows a clock-down (low-power) command. A reset outranks every other exception the core could take. The block drives the core reset for a fixed window. Inside that window it pulses a flush of the load and store pipelines, and at the end of the window it raises a vector-select so that the core fetches from the reset entry.

The block also owns four configuration registers: bus control, memory control, function control and timer prescale. Software writes them through a simple select/write port. Each reset cause carries its own keep mask. Bus control and memory control always return to their reset values. Function control keeps its contents across a clock-down reset, so the wakeup interrupt mask and polarity stay in place. Timer prescale keeps its contents across a watchdog reset, so the time base continues. A two-bit cause code is left for software and maps onto bits 9 and 10 of the status word.

Top module: `rst_seq_ctrl`

## Requirements
- R1: A reset starts on a low-to-high transition of `ext_rst_pin_ni` only. The pin passes through two synchronizer flops and an edge register, so `core_rst_o` rises in the cycle after the third clock edge at which the pin is high. A pin that stays high, or a falling edge, starts nothing.
- R2: A one-cycle high on `wdt_ovf_i` or on `clkdn_rst_i` starts a reset, and `core_rst_o` is high in the cycle after the edge that samples it.
- R3: `core_rst_o` stays high for exactly HOLD_CYC (4) consecutive cycles. A new cause that arrives during the window restarts the full window.
- R4: `pipe_flush_o` is a one-cycle pulse in the first cycle of each reset window.
- R5: `vec_sel_o` is high only in the last cycle of a reset window.
- R6: Bus control and memory control return to their reset values on every cause.
- R7: Function control returns to its reset value on a pin or watchdog reset and keeps its contents on a clock-down reset.
- R8: Timer prescale returns to its reset value on a pin or clock-down reset and keeps its contents on a watchdog reset.
- R9: `cause_o` reads 2'b00 for the pin, 2'b01 for the watchdog and 2'b10 for clock-down. It is updated only when a reset starts. `cause_o[0]` is status bit 9 and `cause_o[1]` is status bit 10.
- R10: When causes coincide in one cycle, the pin wins over the watchdog, and the watchdog wins over clock-down. That cause alone decides both the code and the keep mask.
- R11: A write with `cfg_we_i` high loads `cfg_wdata_i` into the register picked by `cfg_sel_i`: 0 selects bus control, 1 memory control, 2 function control and 3 timer prescale. The write is ignored while `core_rst_o` is high and in the cycle in which a reset starts.
- R12: While `rst_ni` is low, every configuration register holds its reset value, `core_rst_o`, `pipe_flush_o` and `vec_sel_o` are low, and `cause_o` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Block reset, active low |
| ext_rst_pin_ni | input | 1 | External reset pin, asynchronous, active low |
| wdt_ovf_i | input | 1 | Watchdog overrun strobe |
| clkdn_rst_i | input | 1 | Reset strobe that follows a clock-down command |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_sel_i | input | 2 | Configuration register select |
| cfg_wdata_i | input | 16 | Configuration write data |
| core_rst_o | output | 1 | Core reset request |
| pipe_flush_o | output | 1 | Load/store pipeline flush pulse |
| vec_sel_o | output | 1 | Select the reset entry vector |
| cause_o | output | 2 | Cause code of the last reset (status bits 10:9) |
| bus_ctl_o | output | 16 | Bus control register |
| mem_ctl_o | output | 16 | Memory control register |
| fn_ctl_o | output | 16 | Function control register |
| tmr_pre_o | output | 16 | Timer prescale register |

## Verification
The hardest case to reach is a pin edge that lands in exactly the same cycle as a watchdog or clock-down strobe. The pin is delayed by the synchronizer and the edge register, so the bench raises the pin first. It then waits two clock edges and only then pulses the strobes, which makes all causes present in the one cycle the pin edge is detected. The bench sweeps all seven non-empty cause combinations in this way. Before each one it loads distinct values into the four registers, so that each keep mask and the priority show up at the outputs. A write in the cycle a reset starts and a new cause during an open window are both forced with the same cycle counting.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [1:0] {
        CAUSE_PIN   = 2'b00,
        CAUSE_WDT   = 2'b01,
        CAUSE_CLKDN = 2'b10
    } rst_cause_e;

    localparam int NUM_CFG = 4;
    localparam int SEL_W   = $clog2(NUM_CFG);

    localparam int IDX_BUS = 0;
    localparam int IDX_MEM = 1;
    localparam int IDX_FN  = 2;
    localparam int IDX_TMR = 3;

    // one bit per register: 1 = contents survive that cause
    function automatic logic [NUM_CFG-1:0] keep_mask(rst_cause_e c);
        logic [NUM_CFG-1:0] m;
        m = '0;
        case (c)
            CAUSE_WDT:   m[IDX_TMR] = 1'b1;
            CAUSE_CLKDN: m[IDX_FN]  = 1'b1;
            default:     m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_ni,
    output logic rise_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   last;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin_ni};
        st_d.last = st_q.sync[SYNC_STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rise_o = st_q.sync[SYNC_STAGES-1] & ~st_q.last;

    // R1: an edge is a single-cycle event
    assert_rise_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);

endmodule

// File: rtl/rst_cause_arb.sv
module rst_cause_arb
    import rst_seq_pkg::*;
(
    input  logic       pin_rise_i,
    input  logic       wdt_i,
    input  logic       clkdn_i,
    output logic       trig_o,
    output rst_cause_e cause_o
);
    // R10: fixed priority pin > watchdog > clock-down
    always_comb begin
        trig_o  = pin_rise_i | wdt_i | clkdn_i;
        if (pin_rise_i)  cause_o = CAUSE_PIN;
        else if (wdt_i)  cause_o = CAUSE_WDT;
        else             cause_o = CAUSE_CLKDN;
    end

endmodule

// File: rtl/rst_cfg_bank.sv
module rst_cfg_bank
    import rst_seq_pkg::*;
#(
    parameter int                              DATA_W  = 16,
    parameter logic [NUM_CFG-1:0][DATA_W-1:0]  RST_VAL = '0
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             trig_i,
    input  rst_cause_e                       cause_i,
    input  logic                             busy_i,
    input  logic                             we_i,
    input  logic [SEL_W-1:0]                 sel_i,
    input  logic [DATA_W-1:0]                wdata_i,
    output logic [NUM_CFG-1:0][DATA_W-1:0]   cfg_o
);
    typedef struct packed {
        logic [NUM_CFG-1:0][DATA_W-1:0] cfg;
    } bank_st_t;

    bank_st_t           st_d, st_q;
    logic [NUM_CFG-1:0] keep;

    always_comb begin
        keep = keep_mask(cause_i);
        st_d = st_q;
        for (int i = 0; i < NUM_CFG; i++) begin
            if (trig_i) begin
                if (!keep[i]) st_d.cfg[i] = RST_VAL[i];
            end else if (we_i && !busy_i && (sel_i == SEL_W'(i))) begin
                st_d.cfg[i] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q.cfg <= RST_VAL;
        else         st_q     <= st_d;
    end

    assign cfg_o = st_q.cfg;

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_chk
        // R6/R7/R8: cleared registers land on their reset value
        assert_reinit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (trig_i && !keep_mask(cause_i)[g]) |=> (cfg_o[g] == RST_VAL[g]));
        // R7/R8: kept registers do not move, even under a write
        assert_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (trig_i && keep_mask(cause_i)[g]) |=> $stable(cfg_o[g]));
        // R11: no write lands while the core is held in reset
        assert_no_write_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (busy_i && !trig_i) |=> $stable(cfg_o[g]));
    end

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rst_seq_pkg::*;
#(
    parameter int                DATA_W      = 16,
    parameter int                HOLD_CYC    = 4,
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] BUS_RST     = 16'h0013,
    parameter logic [DATA_W-1:0] MEM_RST     = 16'h0025,
    parameter logic [DATA_W-1:0] FN_RST      = 16'h0037,
    parameter logic [DATA_W-1:0] TMR_RST     = 16'h0049
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ext_rst_pin_ni,
    input  logic              wdt_ovf_i,
    input  logic              clkdn_rst_i,
    input  logic              cfg_we_i,
    input  logic [1:0]        cfg_sel_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    output logic              core_rst_o,
    output logic              pipe_flush_o,
    output logic              vec_sel_o,
    output logic [1:0]        cause_o,
    output logic [DATA_W-1:0] bus_ctl_o,
    output logic [DATA_W-1:0] mem_ctl_o,
    output logic [DATA_W-1:0] fn_ctl_o,
    output logic [DATA_W-1:0] tmr_pre_o
);
    localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYC - 1);
    localparam logic [NUM_CFG-1:0][DATA_W-1:0] RST_VAL =
        {TMR_RST, FN_RST, MEM_RST, BUS_RST};

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             flush;
        rst_cause_e       cause;
    } seq_st_t;

    seq_st_t                        st_d, st_q;
    logic                           pin_rise;
    logic                           trig;
    rst_cause_e                     win_cause;
    logic [NUM_CFG-1:0][DATA_W-1:0] cfg;

    rst_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_ni (ext_rst_pin_ni),
        .rise_o (pin_rise)
    );

    rst_cause_arb u_arb (
        .pin_rise_i (pin_rise),
        .wdt_i      (wdt_ovf_i),
        .clkdn_i    (clkdn_rst_i),
        .trig_o     (trig),
        .cause_o    (win_cause)
    );

    rst_cfg_bank #(.DATA_W(DATA_W), .RST_VAL(RST_VAL)) u_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .trig_i  (trig),
        .cause_i (win_cause),
        .busy_i  (st_q.busy),
        .we_i    (cfg_we_i),
        .sel_i   (cfg_sel_i),
        .wdata_i (cfg_wdata_i),
        .cfg_o   (cfg)
    );

    // window sequencer: a new cause always restarts the full window
    always_comb begin
        st_d       = st_q;
        st_d.flush = 1'b0;
        if (trig) begin
            st_d.busy  = 1'b1;
            st_d.cnt   = CNT_LOAD;
            st_d.flush = 1'b1;
            st_d.cause = win_cause;
        end else if (st_q.busy) begin
            if (st_q.cnt == '0) st_d.busy = 1'b0;
            else                st_d.cnt  = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.busy  <= 1'b0;
            st_q.cnt   <= '0;
            st_q.flush <= 1'b0;
            st_q.cause <= CAUSE_PIN;
        end else begin
            st_q <= st_d;
        end
    end

    assign core_rst_o   = st_q.busy;
    assign pipe_flush_o = st_q.flush;
    assign vec_sel_o    = st_q.busy && (st_q.cnt == '0);
    assign cause_o      = st_q.cause;
    assign bus_ctl_o    = cfg[IDX_BUS];
    assign mem_ctl_o    = cfg[IDX_MEM];
    assign fn_ctl_o     = cfg[IDX_FN];
    assign tmr_pre_o    = cfg[IDX_TMR];

    // R2/R3: any cause opens the window at the next edge
    assert_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig |=> (core_rst_o && pipe_flush_o));
    // R4: the flush pulse sits inside the window
    assert_flush_inside_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pipe_flush_o |-> core_rst_o);
    assert_flush_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pipe_flush_o && !trig) |=> !pipe_flush_o);
    // R5: vector select closes the window
    assert_vec_last_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec_sel_o && !trig) |=> !core_rst_o);
    // R9: the cause code moves only when a reset starts
    assert_cause_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !trig |=> $stable(cause_o));
    // R10: a pin edge wins over every coincident cause
    assert_pin_prio_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pin_rise |=> (cause_o == CAUSE_PIN));

endmodule

// File: tb/rst_seq_ctrl_test.sv
module rst_seq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] BUS_RST = 16'h0013;
    localparam logic [15:0] MEM_RST = 16'h0025;
    localparam logic [15:0] FN_RST  = 16'h0037;
    localparam logic [15:0] TMR_RST = 16'h0049;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin = 1'b0;
    logic        wdt = 1'b0;
    logic        clkdn = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  sel = 2'd0;
    logic [15:0] wdata = '0;
    logic        core_rst, flush, vec;
    logic [1:0]  cause;
    logic [15:0] bus_v, mem_v, fn_v, tmr_v;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_seq_ctrl uut (
        .clk_i(clk), .rst_ni(rst_n), .ext_rst_pin_ni(pin),
        .wdt_ovf_i(wdt), .clkdn_rst_i(clkdn),
        .cfg_we_i(we), .cfg_sel_i(sel), .cfg_wdata_i(wdata),
        .core_rst_o(core_rst), .pipe_flush_o(flush), .vec_sel_o(vec),
        .cause_o(cause), .bus_ctl_o(bus_v), .mem_ctl_o(mem_v),
        .fn_ctl_o(fn_v), .tmr_pre_o(tmr_v)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk); we = 1'b1; sel = s; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    // raise the pin (bit0), then pulse watchdog (bit1) / clock-down (bit2)
    // in the very cycle the pin edge is detected; returns just after the start edge
    task automatic fire(input int m);
        @(negedge clk); if (m[0]) pin = 1'b1;
        @(negedge clk);
        @(negedge clk); wdt = m[1]; clkdn = m[2];
        @(negedge clk); wdt = 1'b0; clkdn = 1'b0;
    endtask

    task automatic settle_pin_low();
        @(negedge clk); pin = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R1 falling edge starts nothing", core_rst, 1'b0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] v [4];
        logic [1:0]  exp_cause;
        int          hi;

        repeat (3) @(negedge clk);
        check("R12 core_rst in reset", core_rst, 1'b0);
        check("R12 flush in reset", flush, 1'b0);
        check("R12 vec in reset", vec, 1'b0);
        check("R12 cause in reset", cause, 2'b00);
        check("R12 bus in reset", bus_v, BUS_RST);
        check("R12 mem in reset", mem_v, MEM_RST);
        check("R12 fn in reset", fn_v, FN_RST);
        check("R12 tmr in reset", tmr_v, TMR_RST);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R12 idle after release", core_rst, 1'b0);

        // sweep of all coincident cause sets
        for (int m = 1; m < 8; m++) begin
            settle_pin_low();
            for (int i = 0; i < 4; i++) begin
                v[i] = 16'h1000 * 16'(i + 1) + 16'(m) * 16'h0011;
                wr(2'(i), v[i]);
            end
            check("R11 write bus", bus_v, v[0]);
            check("R11 write mem", mem_v, v[1]);
            check("R11 write fn", fn_v, v[2]);
            check("R11 write tmr", tmr_v, v[3]);
            exp_cause = m[0] ? 2'b00 : (m[1] ? 2'b01 : 2'b10);
            fire(m);
            for (int c = 0; c < 6; c++) begin
                check("R1/R2/R3 core_rst window", core_rst, (c < 4) ? 1'b1 : 1'b0);
                check("R4 flush first cycle", flush, (c == 0) ? 1'b1 : 1'b0);
                check("R5 vec last cycle", vec, (c == 3) ? 1'b1 : 1'b0);
                if (c == 0) begin
                    check("R9/R10 cause code", cause, exp_cause);
                    check("R6 bus reinit", bus_v, BUS_RST);
                    check("R6 mem reinit", mem_v, MEM_RST);
                    check("R7 fn keep/reinit", fn_v, (exp_cause == 2'b10) ? v[2] : FN_RST);
                    check("R8 tmr keep/reinit", tmr_v, (exp_cause == 2'b01) ? v[3] : TMR_RST);
                end
                @(negedge clk);
            end
            check("R9 cause held after window", cause, exp_cause);
        end

        // pin held high: no further reset
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            check("R1 steady high level starts nothing", core_rst, 1'b0);
        end
        settle_pin_low();

        // write during an open window is dropped
        fire(2);
        we = 1'b1; sel = 2'd0; wdata = 16'hFFFF;
        @(negedge clk); we = 1'b0;
        repeat (6) @(negedge clk);
        check("R11 write in window ignored", bus_v, BUS_RST);

        // write in the start cycle to a kept register is dropped
        wr(2'd3, 16'h5A5A);
        @(negedge clk); wdt = 1'b1; we = 1'b1; sel = 2'd3; wdata = 16'hBEEF;
        @(negedge clk); wdt = 1'b0; we = 1'b0;
        check("R11 write at start ignored", tmr_v, 16'h5A5A);
        check("R2 watchdog starts reset", core_rst, 1'b1);
        repeat (6) @(negedge clk);

        // clock-down strobe alone
        @(negedge clk); clkdn = 1'b1;
        @(negedge clk); clkdn = 1'b0;
        check("R2 clock-down starts reset", core_rst, 1'b1);
        check("R9 clock-down code", cause, 2'b10);
        repeat (6) @(negedge clk);

        // retrigger inside the window extends it
        fire(2);
        hi = 0;
        if (core_rst) hi++;
        @(negedge clk);
        if (core_rst) hi++;
        wdt = 1'b1;
        @(negedge clk);
        wdt = 1'b0;
        check("R4 flush on restart", flush, 1'b1);
        if (core_rst) hi++;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (core_rst) hi++;
        end
        check("R3 restarted window length", hi, 6);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule